// File: doc/BRIEF.md
# Multi-cycle accumulator processor core

A small stored-program processor. Instructions and data share one internal word memory. The datapath holds a program counter, an address latch, a data latch, an instruction latch and one accumulator. A control sequencer moves one register transfer per clock through fetch, decode and execute phases. A 12-bit instruction word carries a 4-bit operation code in bits 11:8 and an 8-bit memory address in bits 7:0. Arithmetic wraps modulo 2^12.

A host fills the memory through a write-only preload port, usually while reset is held, and then releases reset. Execution starts at address 0 and runs until a halt instruction. One instruction exchanges words with the outside world: it either waits on a ready/valid input port or emits the accumulator with a one-cycle valid strobe.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low, the PC and accumulator are 0, and halted_o, in_ready_o and out_valid_o are low. The first fetch after release reads address 0.
- R2: Each fetch copies the PC to the address latch, reads memory while the PC advances by one, latches the read word, then moves it to the instruction latch. Bits 11:8 form the opcode and bits 7:0 the address operand.
- R3: Opcode 0x1 adds the addressed word to the accumulator. Opcode 0x2 subtracts it. Both wrap modulo 2^12.
- R4: Opcode 0x5 loads the addressed word into the accumulator. Opcode 0x3 writes the accumulator to the addressed word.
- R5: Opcode 0x6 sets the PC to the operand unconditionally.
- R6: Opcode 0x7 sets the PC to the operand only when the accumulator is zero.
- R7: Opcode 0x8 sets the PC to the operand only when accumulator bit 11 is 0.
- R8: Opcode 0x9 with operand 0x01 raises in_ready_o and holds it, with the accumulator unchanged, until in_valid_i is high. On that cycle in_data_i is loaded into the accumulator.
- R9: Opcode 0x9 with operand 0x02 places the accumulator on out_data_o with out_valid_o high for exactly one cycle.
- R10: Opcode 0x0 raises halted_o. From then until reset, the PC, accumulator and outputs do not change, and in_valid_i is ignored.
- R11: Opcodes 0x4 and 0xA to 0xF change nothing but the PC advance of their fetch.
- R12: A preload write (ld_we_i high) stores ld_data_i at ld_addr_i on any clock edge, whether reset is held, the core is running or the core is halted. It takes priority over a store from the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Preload write enable |
| ld_addr_i | input | 8 | Preload word address |
| ld_data_i | input | 12 | Preload word |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 12 | Input word |
| in_ready_o | output | 1 | Core is waiting for an input word |
| out_valid_o | output | 1 | One-cycle strobe for out_data_o |
| out_data_o | output | 12 | Output word (accumulator copy) |
| halted_o | output | 1 | Core has executed a halt |

## Verification
Arithmetic is exercised with operands that cross the sign boundary upward and that wrap through zero in both directions. This separates true modulo-2^12 behaviour from saturating or width-truncated sums. Branch programs place each conditional branch on a zero, a positive and a negative accumulator, and put a distinct output on each wrong path. A single output count and sequence then shows which branch went astray. Input is offered both at once and after a stall, and memory is preloaded during reset and again while halted. This separates a handshake that waits correctly from one that samples early, and a preload that is gated by core state from one that is not.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HLT = 4'h0;
  localparam logic [OPC_W-1:0] OP_ADD = 4'h1;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h2;
  localparam logic [OPC_W-1:0] OP_STO = 4'h3;
  localparam logic [OPC_W-1:0] OP_LDA = 4'h5;
  localparam logic [OPC_W-1:0] OP_JMP = 4'h6;
  localparam logic [OPC_W-1:0] OP_BRZ = 4'h7;
  localparam logic [OPC_W-1:0] OP_BRP = 4'h8;
  localparam logic [OPC_W-1:0] OP_IO  = 4'h9;

  localparam int IO_SEL_IN  = 1;
  localparam int IO_SEL_OUT = 2;

  typedef enum logic [3:0] {
    PH_PC2MAR, PH_MEMRD, PH_MDR, PH_CIR, PH_DEC,
    PH_OPRD, PH_OPMDR, PH_EXEC, PH_STMDR, PH_STWR,
    PH_IO, PH_HALT
  } phase_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} alu_op_e;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              pl_we_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // preload has priority over core store
  always_ff @(posedge clk_i) begin
    if (pl_we_i)   mem_q[pl_addr_i] <= pl_data_i;
    else if (we_i) mem_q[addr_i]    <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [ADDR_W-1:0] operand_i,
  input  logic              acc_zero_i,
  input  logic              acc_neg_i,
  input  logic              in_valid_i,
  output phase_e            phase_o,
  output logic              br_take_o,
  output alu_op_e           alu_op_o,
  output logic              in_ready_o,
  output logic              out_fire_o
);
  phase_e phase_q, phase_d;
  logic   sel_in, sel_out;

  assign sel_in  = operand_i == ADDR_W'(IO_SEL_IN);
  assign sel_out = operand_i == ADDR_W'(IO_SEL_OUT);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_PC2MAR: phase_d = PH_MEMRD;
      PH_MEMRD:  phase_d = PH_MDR;
      PH_MDR:    phase_d = PH_CIR;
      PH_CIR:    phase_d = PH_DEC;
      PH_DEC: begin
        unique case (opcode_i)
          OP_HLT:                 phase_d = PH_HALT;
          OP_ADD, OP_SUB, OP_LDA: phase_d = PH_OPRD;
          OP_STO:                 phase_d = PH_STMDR;
          OP_IO:                  phase_d = (sel_in || sel_out) ? PH_IO : PH_PC2MAR;
          default:                phase_d = PH_PC2MAR;
        endcase
      end
      PH_OPRD:   phase_d = PH_OPMDR;
      PH_OPMDR:  phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_PC2MAR;
      PH_STMDR:  phase_d = PH_STWR;
      PH_STWR:   phase_d = PH_PC2MAR;
      PH_IO:     phase_d = (sel_in && !in_valid_i) ? PH_IO : PH_PC2MAR;
      PH_HALT:   phase_d = PH_HALT;
      default:   phase_d = PH_PC2MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_PC2MAR;
    else         phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  assign br_take_o  = (phase_q == PH_DEC) &&
                      ((opcode_i == OP_JMP) ||
                       (opcode_i == OP_BRZ && acc_zero_i) ||
                       (opcode_i == OP_BRP && !acc_neg_i));
  assign in_ready_o = (phase_q == PH_IO) && sel_in;
  assign out_fire_o = (phase_q == PH_IO) && sel_out;

  always_comb begin
    unique case (opcode_i)
      OP_ADD:  alu_op_o = ALU_ADD;
      OP_SUB:  alu_op_o = ALU_SUB;
      default: alu_op_o = ALU_PASS;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              halted_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q, mem_rdata, alu_y;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] operand;
  phase_e            phase;
  alu_op_e           alu_op;
  logic              br_take, out_fire;

  assign opcode  = cir_q[DATA_W-1 -: OPC_W];
  assign operand = cir_q[ADDR_W-1:0];

  acc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (opcode),
    .operand_i  (operand),
    .acc_zero_i (acc_q == '0),
    .acc_neg_i  (acc_q[DATA_W-1]),
    .in_valid_i (in_valid_i),
    .phase_o    (phase),
    .br_take_o  (br_take),
    .alu_op_o   (alu_op),
    .in_ready_o (in_ready_o),
    .out_fire_o (out_fire)
  );

  acc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .pl_we_i   (ld_we_i),
    .pl_addr_i (ld_addr_i),
    .pl_data_i (ld_data_i),
    .we_i      (phase == PH_STWR),
    .addr_i    (mar_q),
    .wdata_i   (mdr_q),
    .rdata_o   (mem_rdata)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (alu_op),
    .a_i  (acc_q),
    .b_i  (mdr_q),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= '0;
      mar_q       <= '0;
      mdr_q       <= '0;
      cir_q       <= '0;
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= out_fire;
      if (out_fire) out_data_o <= acc_q;
      unique case (phase)
        PH_PC2MAR: mar_q <= pc_q;
        PH_MEMRD:  pc_q  <= pc_q + 1'b1;
        PH_MDR:    mdr_q <= mem_rdata;
        PH_CIR:    cir_q <= mdr_q;
        PH_DEC: begin
          mar_q <= operand;
          if (br_take) pc_q <= operand;
        end
        PH_OPMDR:  mdr_q <= mem_rdata;
        PH_EXEC:   acc_q <= alu_y;
        PH_STMDR:  mdr_q <= acc_q;
        PH_IO:     if (in_ready_o && in_valid_i) acc_q <= in_data_i;
        default: ;
      endcase
    end
  end

  assign halted_o = phase == PH_HALT;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              halted_o,
  input phase_e            phase_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] cir_i
);
  logic [OPC_W-1:0]  op;
  logic [ADDR_W-1:0] opd;
  logic              dec;
  assign op  = cir_i[DATA_W-1 -: OPC_W];
  assign opd = cir_i[ADDR_W-1:0];
  assign dec = phase_i == PH_DEC;

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_MEMRD |=> pc_i == $past(pc_i) + ADDR_W'(1));

  p_jump_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec && op == OP_JMP |=> pc_i == $past(opd));

  p_brz_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec && op == OP_BRZ && acc_i != '0 |=> pc_i == $past(pc_i));

  p_brp_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec && op == OP_BRP && !acc_i[DATA_W-1] |=> pc_i == $past(opd));

  p_in_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o && $stable(acc_i));

  p_out_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(acc_i) && $stable(pc_i));

  p_halt_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !in_ready_o && !out_valid_o);

  p_nop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec && (op == 4'h4 || op >= 4'hA) |=> $stable(acc_i) && phase_i == PH_PC2MAR);
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .halted_o    (halted_o),
  .phase_i     (phase),
  .pc_i        (pc_q),
  .acc_i       (acc_q),
  .cir_i       (cir_q)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        in_ready, out_valid, halted;
  logic [11:0] out_data;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [11:0] img [256];
  logic [11:0] obuf [16];
  int ocnt = 0;
  int pulse_err = 0;
  logic prev_ov = 1'b0;

  always #10 clk = ~clk;

  acc_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ld_we_i(ld_we), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .halted_o(halted)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_ni && out_valid) begin
      if (ocnt < 16) obuf[ocnt] = out_data;
      ocnt++;
    end
    if (out_valid && prev_ov) pulse_err++;
    prev_ov = out_valid;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 12'h000;
  endtask

  task automatic load_all();
    for (int i = 0; i < 256; i++) begin
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic boot();
    @(negedge clk);
    rst_ni = 1'b0;
    load_all();
    ocnt = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_halt(string tag);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 12'(halted), 12'h001);
  endtask

  task automatic supply(logic [11:0] d, int hold);
    int n = 0;
    while (!in_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R8 ready raised", 12'(in_ready), 12'h001);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R8 ready held while waiting", 12'(in_ready), 12'h001);
    end
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_data = 12'h000;
  endtask

  task automatic t_reset();
    clear_img();
    img[0] = 12'h902; img[1] = 12'h000;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 halted in reset", 12'(halted), 12'h000);
    chk("R1 in_ready in reset", 12'(in_ready), 12'h000);
    chk("R1 out_valid in reset", 12'(out_valid), 12'h000);
    boot();
    wait_halt("R1 halt after run");
    chk("R1 one output", 12'(ocnt), 12'h001);
    chk("R1 acc cleared, start at 0", obuf[0], 12'h000);
  endtask

  task automatic t_arith();
    clear_img();
    img[0] = 12'h520; img[1] = 12'h121; img[2] = 12'h902;
    img[3] = 12'h222; img[4] = 12'h902; img[5] = 12'h123;
    img[6] = 12'h902; img[7] = 12'h000;
    img[8'h20] = 12'h7FF; img[8'h21] = 12'h001;
    img[8'h22] = 12'h801; img[8'h23] = 12'h003;
    boot();
    wait_halt("R2 arith program halts");
    chk("R3 output count", 12'(ocnt), 12'h003);
    chk("R3 add across sign", obuf[0], 12'h800);
    chk("R3 sub wraps below zero", obuf[1], 12'hFFF);
    chk("R3 add wraps past max", obuf[2], 12'h002);
  endtask

  task automatic t_mem();
    clear_img();
    img[0] = 12'h530; img[1] = 12'h331; img[2] = 12'h532;
    img[3] = 12'h902; img[4] = 12'h531; img[5] = 12'h902;
    img[6] = 12'h000;
    img[8'h30] = 12'h5A5; img[8'h31] = 12'h111; img[8'h32] = 12'h000;
    boot();
    wait_halt("R4 mem program halts");
    chk("R4 output count", 12'(ocnt), 12'h002);
    chk("R4 load of zero", obuf[0], 12'h000);
    chk("R4 stored word read back", obuf[1], 12'h5A5);
  endtask

  task automatic t_branch();
    clear_img();
    img[0]  = 12'h540; img[1]  = 12'h704; img[2]  = 12'h902; img[3]  = 12'h000;
    img[4]  = 12'h807; img[5]  = 12'h902; img[6]  = 12'h000;
    img[7]  = 12'h541; img[8]  = 12'h70C; img[9]  = 12'h80C; img[10] = 12'h902;
    img[11] = 12'h60D; img[12] = 12'h902;
    img[13] = 12'h542; img[14] = 12'h711; img[15] = 12'h812; img[16] = 12'h000;
    img[17] = 12'h902; img[18] = 12'h902; img[19] = 12'h000;
    img[8'h40] = 12'h000; img[8'h41] = 12'h800; img[8'h42] = 12'h001;
    boot();
    wait_halt("R5 branch program halts");
    chk("R6 R7 R5 path output count", 12'(ocnt), 12'h002);
    chk("R7 negative not taken, R5 jump", obuf[0], 12'h800);
    chk("R6 nonzero not taken, R7 positive taken", obuf[1], 12'h001);
  endtask

  task automatic t_io();
    clear_img();
    img[0] = 12'h901; img[1] = 12'h902; img[2] = 12'h901;
    img[3] = 12'h150; img[4] = 12'h902; img[5] = 12'h000;
    img[8'h50] = 12'h010;
    boot();
    supply(12'h123, 6);
    supply(12'hABC, 0);
    wait_halt("R8 io program halts");
    chk("R9 output count", 12'(ocnt), 12'h002);
    chk("R8 stalled input captured", obuf[0], 12'h123);
    chk("R9 immediate input plus add", obuf[1], 12'hACC);
    chk("R9 strobe one cycle wide", 12'(pulse_err), 12'h000);
  endtask

  task automatic t_nop();
    clear_img();
    img[0] = 12'h560; img[1] = 12'h400; img[2] = 12'hA00; img[3] = 12'hBFF;
    img[4] = 12'hC12; img[5] = 12'hD00; img[6] = 12'hE00; img[7] = 12'hF55;
    img[8] = 12'h902; img[9] = 12'h000;
    img[8'h60] = 12'h321;
    boot();
    wait_halt("R11 nop program halts");
    chk("R11 output count", 12'(ocnt), 12'h001);
    chk("R11 acc untouched by nops", obuf[0], 12'h321);
  endtask

  task automatic t_halt();
    clear_img();
    img[0] = 12'h000; img[1] = 12'h902;
    boot();
    wait_halt("R10 halt reached");
    in_valid = 1'b1; in_data = 12'h777;
    for (int k = 0; k < 20; k++) @(negedge clk);
    in_valid = 1'b0;
    chk("R10 stays halted", 12'(halted), 12'h001);
    chk("R10 no ready when halted", 12'(in_ready), 12'h000);
    chk("R10 no output after halt", 12'(ocnt), 12'h000);
    clear_img();
    img[0] = 12'h570; img[1] = 12'h902; img[2] = 12'h000;
    img[8'h70] = 12'h5C3;
    load_all();
    chk("R10 R12 halted during preload", 12'(halted), 12'h001);
    @(negedge clk);
    rst_ni = 1'b0;
    ocnt = 0;
    @(negedge clk);
    chk("R1 reset clears halted", 12'(halted), 12'h000);
    rst_ni = 1'b1;
    wait_halt("R12 reloaded program halts");
    chk("R12 output count", 12'(ocnt), 12'h001);
    chk("R12 preload while halted took effect", obuf[0], 12'h5C3);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    t_reset();
    t_arith();
    t_mem();
    t_branch();
    t_io();
    t_nop();
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule